// File: doc/BRIEF.md
# Fractional-Rate PWM Generator

This block drives a single pulse-width-modulated output from one 32-bit control word. The period comes from a 16-bit phase accumulator that adds a programmable step on every clock, so the output rate is the clock rate times step/65536 and can be set in fine fractional increments. The duty cycle comes from an 8-bit threshold compared against the top byte of the accumulator. The threshold is inverted: a small code gives a long high time, and a large code gives a short one.

Software writes the step, the threshold, a run bit and an apply-request bit together. The step and threshold land in a pending copy first. They are moved into the active copy that drives the accumulator and comparator only when the apply request is set, and only at a period boundary (an accumulator wrap). While the generator is idle the move happens at once. The request bit clears itself when the move is done, so software can poll it. The word reads back as stored, so software can read, modify and write it.

Top module: `fracPwmGen`

## Requirements
- R1: After reset the control word reads 0 and the output is low.
- R2: Control word layout: bit 31 is run, bit 30 is apply-request, bits 23:8 are the step, and bits 7:0 are the threshold. A write stores all four fields, which read back on the next clock. Bits 29:24 are not stored and read as 0.
- R3: While running, the accumulator adds the active step every clock. For a step that is a power of two, the output period is exactly 65536/step clocks.
- R4: The output is high, one clock after the fact, when the top 8 bits of the accumulator are at least the active threshold. For a period P, the number of high clocks is the count of k in 0..P-1 with (k*step)>>8 >= threshold. Threshold 0 gives a constant high and threshold 255 gives a constant low at step 0x1000.
- R5: While running with a nonzero active step, a pending apply-request moves the step and threshold into the active copy only on a clock where the accumulator wraps past 65535. The request bit reads 1 until then, and within one period it clears. A write with the request bit at 0 leaves the active settings untouched.
- R6: While idle (run clear, or active step zero), a pending apply-request is moved on the next clock and the request bit reads 0 afterwards.
- R7: When run is clear, the accumulator is held at zero and the output is low from the next clock on.
- R8: A running generator with an active step of zero holds its accumulator, so the output level stays frozen (constantly high for threshold 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 32 | Control word write value |
| rdData | output | 32 | Control word read value |
| pwmOut | output | 1 | PWM output |

## Verification
The assertions assume that software writes the control word with single-clock strobes and that wrData is stable whenever wrEn is high. They also assume that a write in the same clock as an automatic transfer is allowed to win and re-arm the request. The stimulus drives each write for exactly one clock, away from the active edge, and sweeps power-of-two steps so that every wrap lands exactly on zero. This makes the expected high-time counts exact per period. The stimulus also waits for the request bit to clear before it measures duty, so every duty window falls wholly inside one setting.

// File: rtl/fracPwmPkg.sv
package fracPwmPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic run;   // generator enabled
    logic load;  // copy pending settings into active copy this clock
  } pwmStrobe_t;
endpackage

// File: rtl/fracPwmCtrl.sv
module fracPwmCtrl
  import fracPwmPkg::*;
#(
  parameter int REG_W = 32,
  parameter int ACC_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             wrap,
  input  logic             idle,
  output pwmStrobe_t       strobe,
  output logic [ACC_W-1:0] pendBase,
  output logic [DIV_W-1:0] pendDiv,
  output logic [REG_W-1:0] rdData
);
  localparam int RUN_BIT  = REG_W - 1;
  localparam int REQ_BIT  = REG_W - 2;
  localparam int STEP_LSB = DIV_W;
  localparam int STEP_MSB = DIV_W + ACC_W - 1;

  logic runQ, reqQ;

  assign strobe.run  = runQ;
  assign strobe.load = reqQ && (wrap || idle);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      reqQ     <= 1'b0;
      pendBase <= '0;
      pendDiv  <= '0;
    end else if (wrEn) begin
      runQ     <= wrData[RUN_BIT];
      reqQ     <= wrData[REQ_BIT];
      pendBase <= wrData[STEP_MSB:STEP_LSB];
      pendDiv  <= wrData[DIV_W-1:0];
    end else if (strobe.load) begin
      reqQ <= 1'b0;
    end
  end

  always_comb begin
    rdData                    = '0;
    rdData[RUN_BIT]           = runQ;
    rdData[REQ_BIT]           = reqQ;
    rdData[STEP_MSB:STEP_LSB] = pendBase;
    rdData[DIV_W-1:0]         = pendDiv;
  end

  // R6
  idle_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqQ && idle && !wrEn) |=> !reqQ);
  // R5
  req_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqQ) |-> ($past(strobe.load) || $past(wrEn)));
endmodule

// File: rtl/fracPwmDp.sv
module fracPwmDp
  import fracPwmPkg::*;
#(
  parameter int ACC_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strobe,
  input  logic [ACC_W-1:0] pendBase,
  input  logic [DIV_W-1:0] pendDiv,
  output logic             wrap,
  output logic             idle,
  output logic             pwmOut
);
  localparam int TOP_LSB = ACC_W - DIV_W;

  logic [ACC_W-1:0] acc, activeBase;
  logic [DIV_W-1:0] activeDiv;
  logic [ACC_W:0]   accSum;
  logic             pwmQ;

  assign accSum = {1'b0, acc} + {1'b0, activeBase};
  assign wrap   = strobe.run && accSum[ACC_W];
  assign idle   = !strobe.run || (activeBase == '0);
  assign pwmOut = pwmQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeBase <= '0;
      activeDiv  <= '0;
    end else if (strobe.load) begin
      activeBase <= pendBase;
      activeDiv  <= pendDiv;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.run) begin
      acc  <= '0;
      pwmQ <= 1'b0;
    end else begin
      acc  <= accSum[ACC_W-1:0];
      pwmQ <= (acc[ACC_W-1:TOP_LSB] >= activeDiv);
    end
  end

  // R7
  stop_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> (acc == '0) && !pwmOut);
  // R8
  zero_step_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && activeBase == '0 && !strobe.load) |=> $stable(acc));
  // R5
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(activeBase) && $stable(activeDiv)));
endmodule

// File: rtl/fracPwmGen.sv
module fracPwmGen
  import fracPwmPkg::*;
#(
  parameter int REG_W = 32,
  parameter int ACC_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             pwmOut
);
  pwmStrobe_t       strobe;
  logic [ACC_W-1:0] pendBase;
  logic [DIV_W-1:0] pendDiv;
  logic             wrap, idle;

  fracPwmCtrl #(.REG_W(REG_W), .ACC_W(ACC_W), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .wrap(wrap), .idle(idle), .strobe(strobe),
    .pendBase(pendBase), .pendDiv(pendDiv), .rdData(rdData)
  );

  fracPwmDp #(.ACC_W(ACC_W), .DIV_W(DIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pendBase(pendBase), .pendDiv(pendDiv),
    .wrap(wrap), .idle(idle), .pwmOut(pwmOut)
  );
endmodule

// File: tb/fracPwmGen_tb.sv
module fracPwmGen_tb_top;
  localparam int CLK_P = 10;
  localparam int NVEC  = 7;
  // {step[15:0], threshold[7:0], high clocks per period[15:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h1000, 8'h80, 16'd8},
    {16'h1000, 8'h00, 16'd16},
    {16'h1000, 8'hFF, 16'd0},
    {16'h0800, 8'h40, 16'd24},
    {16'h4000, 8'hC0, 16'd1},
    {16'h2000, 8'h20, 16'd7},
    {16'h8000, 8'h80, 16'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        pwmOut;
  int          nChk = 0;
  int          nBad = 0;

  fracPwmGen dut_i (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
                    .rdData(rdData), .pwmOut(pwmOut));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeWord(input logic [31:0] v);
    @(negedge clk); wrEn = 1'b1; wrData = v;
    @(negedge clk); wrEn = 1'b0;
  endtask

  function automatic logic [31:0] word(bit run, bit req, logic [15:0] st, logic [7:0] th);
    return {run, req, 6'b0, st, th};
  endfunction

  // waits for the request bit to clear, returns clocks waited
  task automatic waitApply(output int n);
    n = 0;
    while (rdData[30] && n < 100000) begin @(negedge clk); n++; end
  endtask

  task automatic countHigh(input int len, output int hi);
    hi = 0;
    for (int i = 0; i < len; i++) begin @(negedge clk); if (pwmOut) hi++; end
  endtask

  initial begin
    #(CLK_P*150000);
    nBad++; nChk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int n, hi, per;
    repeat (3) @(negedge clk);
    check(rdData == 32'h0, "R1 reset word", rdData, 0);
    check(pwmOut == 1'b0, "R1 reset output", pwmOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 readback, dropped bits; R6 idle apply
    writeWord(32'h0012_3456);
    check(rdData == 32'h0012_3456, "R2 readback", rdData, 32'h0012_3456);
    writeWord(32'h7F00_0000);
    check(rdData == 32'h4000_0000, "R2 unused bits", rdData, 32'h4000_0000);
    @(negedge clk);
    check(rdData == 32'h0, "R6 idle apply clears request", rdData, 0);

    // table: R3/R4 duty and period per step
    for (int v = 0; v < NVEC; v++) begin
      writeWord(word(1'b1, 1'b1, VEC[v][39:24], VEC[v][23:16]));
      waitApply(n);
      per = 65536 / int'(VEC[v][39:24]);
      repeat (2) @(negedge clk);
      countHigh(4*per, hi);
      check(hi == 4*int'(VEC[v][15:0]), "R4 duty count", hi, 4*int'(VEC[v][15:0]));
    end

    // R5 deferred apply while running at step 0x1000, threshold 0x80
    writeWord(word(1'b1, 1'b1, 16'h1000, 8'h80));
    waitApply(n);
    repeat (2) @(negedge clk);
    writeWord(word(1'b1, 1'b0, 16'h1000, 8'hFF));
    countHigh(64, hi);
    check(hi == 32, "R5 no-request write ignored", hi, 32);
    writeWord(word(1'b1, 1'b1, 16'h1000, 8'h00));
    check(rdData[30] == 1'b1, "R5 request pending", rdData[30], 1);
    waitApply(n);
    check(n <= 16, "R5 applied within one period", n, 16);
    repeat (2) @(negedge clk);
    countHigh(32, hi);
    check(hi == 32, "R5 new threshold active", hi, 32);

    // R7 stop
    writeWord(word(1'b0, 1'b0, 16'h1000, 8'h00));
    @(negedge clk);
    countHigh(40, hi);
    check(hi == 0, "R7 stopped output low", hi, 0);
    check(rdData == word(1'b0, 1'b0, 16'h1000, 8'h00), "R2 stopped word", rdData,
          word(1'b0, 1'b0, 16'h1000, 8'h00));

    // R8 zero step freezes level
    writeWord(word(1'b0, 1'b1, 16'h0000, 8'h00));
    @(negedge clk);
    writeWord(word(1'b1, 1'b0, 16'h0000, 8'h00));
    @(negedge clk);
    countHigh(40, hi);
    check(hi == 40, "R8 frozen high", hi, 40);

    // R3 period: step 0x2000 threshold 0xE0 gives one pulse every 8 clocks
    writeWord(word(1'b1, 1'b1, 16'h2000, 8'hE0));
    waitApply(n);
    repeat (2) @(negedge clk);
    countHigh(80, hi);
    check(hi == 10, "R3 period 8 clocks", hi, 10);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule